// File: doc/BRIEF.md
# Configuration Packet Stream Parser

This block sits on the path that carries configuration words into a programmable device's configuration engine. Words arrive 32 bits at a time with a valid/ready handshake. The parser throws away everything, padding included, until it sees the synchronization word. After that it reads packet headers and sends each payload word to a register-write port. That port carries the target register address, the data word and the operation code of the packet.

There are two header formats. The short format names a target register and carries an 11-bit word count. The long format carries only a 27-bit word count and reuses the register named by the most recent short header. Words written to the frame-data register also appear on a separate frame-word output, and a completion pulse marks each full frame. Words written to the frame-address register update a decoded view of the current frame address. If an address is numerically below the one before it, a sticky error flag is raised. A write of the desynchronize code to the command register sends the parser back to hunting for the synchronization word.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset, every accepted word is discarded until the word 0xAA995566 is accepted, and no write strobe occurs while hunting. `synced` rises in the cycle after that word is accepted.
- R2: A header with bits[31:29]=001 is a short header. Opcode is bits[28:27] (00 no-op, 01 read, 10 write, 11 decrypt-write), register is bits[17:13] and count is bits[10:0]. For a write, each of the following count words produces one `wr_valid` pulse with `wr_addr`, `wr_data` and `wr_op`, in the cycle after that word is accepted.
- R3: A header with bits[31:29]=010 is a long header. Its count is bits[26:0] and its opcode is bits[28:27]. Its payload goes to the register named by the most recent short header.
- R4: A header whose opcode is no-op or whose count is zero consumes no payload, so the next word is parsed as a header.
- R5: While synchronized and expecting a header, a word whose bits[31:29] are neither 001 nor 010 sets the sticky `bad_hdr` flag and is skipped. The synchronization word itself is skipped without setting the flag.
- R6: Write payload words to register 00010 (frame data in) also appear on `frm_valid`/`frm_data` in the same cycle as their `wr_valid`.
- R7: `frm_done` pulses together with every 81st frame-data word, counted since reset.
- R8: A write to register 00001 (frame address) updates the fields block [23:21], bottom [20], row [19:15], major [14:7] and minor [6:0]. If the word is numerically lower than the previous frame address, the sticky `far_err` flag is set.
- R9: A write (opcode 10) to register 00100 (command) with data[4:0]=01101 clears `synced` in the same cycle as its strobe. Later words are ignored until the next 0xAA995566.
- R10: Payload words of a read packet are counted past without any `wr_valid`.
- R11: Decrypt-write packets strobe their words like writes, with `wr_op`=11.
- R12: After reset, `synced`, `wr_valid`, `frm_valid`, `frm_done`, `bad_hdr` and `far_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input configuration word |
| in_ready | output | 1 | Always ready to accept a word |
| synced | output | 1 | Parser is synchronized |
| wr_valid | output | 1 | Register-write strobe |
| wr_addr | output | 5 | Target register address |
| wr_data | output | 32 | Payload word |
| wr_op | output | 2 | Packet opcode |
| frm_valid | output | 1 | Frame-data word strobe |
| frm_data | output | 32 | Frame-data word |
| frm_done | output | 1 | Frame completion pulse |
| far_block | output | 3 | Current frame address block type |
| far_bottom | output | 1 | Current frame address bottom half |
| far_row | output | 5 | Current frame address row |
| far_major | output | 8 | Current frame address major column |
| far_minor | output | 7 | Current frame address minor index |
| far_err | output | 1 | Sticky descending frame address flag |
| bad_hdr | output | 1 | Sticky malformed header flag |

## Verification
Two events can land in the same cycle. The desynchronize command is itself a register write, so its `wr_valid` strobe appears in the very cycle that `synced` falls. The bench sends that command and checks the strobe, the command data and the dropped sync state from a single sample. It then confirms that a following register-write packet produces no strobe. The 81st word of a long frame-data packet likewise raises `wr_valid`, `frm_valid` and `frm_done` together, and the bench checks that the pulse appears on exactly that word and on no other.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 27;

    localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA99_5566;

    localparam logic [ADDR_W-1:0] RSEL_FAR  = 5'b00001;
    localparam logic [ADDR_W-1:0] RSEL_FDRI = 5'b00010;
    localparam logic [ADDR_W-1:0] RSEL_CMD  = 5'b00100;
    localparam logic [4:0]        CMD_DESYNC = 5'b01101;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_DEC = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PS_HUNT,
        PS_HDR,
        PS_PAY
    } pstate_e;

    typedef struct packed {
        logic              is_short;
        logic              is_long;
        op_e               op;
        logic [ADDR_W-1:0] rsel;
        logic [CNT_W-1:0]  cnt;
    } hdr_s;

    function automatic logic op_stores(op_e op);
        return (op == OP_WR) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/cfgp_hdr_decode.sv
module cfgp_hdr_decode
    import cfgp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] last_rsel,
    output hdr_s              hdr
);
    always_comb begin
        hdr.is_short = (word[31:29] == 3'b001);
        hdr.is_long  = (word[31:29] == 3'b010);
        hdr.op       = op_e'(word[28:27]);
        if (hdr.is_short) begin
            hdr.rsel = word[17:13];
            hdr.cnt  = {{(CNT_W-11){1'b0}}, word[10:0]};
        end else begin
            hdr.rsel = last_rsel;
            hdr.cnt  = word[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/cfgp_frame_track.sv
module cfgp_frame_track
    import cfgp_pkg::*;
#(
    parameter int FRAME_WORDS = 81
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fdata_stb,
    input  logic              faddr_stb,
    input  logic [WORD_W-1:0] word,
    output logic              frame_done,
    output logic [WORD_W-1:0] faddr_q,
    output logic              faddr_err
);
    localparam int FCNT_W = $clog2(FRAME_WORDS);

    logic [FCNT_W-1:0] fcnt;
    logic              faddr_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (fdata_stb) begin
                if (fcnt == FCNT_W'(FRAME_WORDS - 1)) begin
                    fcnt       <= '0;
                    frame_done <= 1'b1;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            faddr_q    <= '0;
            faddr_seen <= 1'b0;
            faddr_err  <= 1'b0;
        end else if (faddr_stb) begin
            if (faddr_seen && (word < faddr_q))
                faddr_err <= 1'b1;
            faddr_q    <= word;
            faddr_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfgp_pkg::*;
#(
    parameter int FRAME_WORDS = 81
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        synced,
    output logic        wr_valid,
    output logic [4:0]  wr_addr,
    output logic [31:0] wr_data,
    output logic [1:0]  wr_op,
    output logic        frm_valid,
    output logic [31:0] frm_data,
    output logic        frm_done,
    output logic [2:0]  far_block,
    output logic        far_bottom,
    output logic [4:0]  far_row,
    output logic [7:0]  far_major,
    output logic [6:0]  far_minor,
    output logic        far_err,
    output logic        bad_hdr
);
    pstate_e           state;
    hdr_s              hdr;
    logic [ADDR_W-1:0] last_rsel;
    logic [ADDR_W-1:0] cur_rsel;
    op_e               cur_op;
    logic [CNT_W-1:0]  remain;
    logic [WORD_W-1:0] faddr_q;
    logic              pay_take;
    logic              fdata_stb;
    logic              faddr_stb;

    cfgp_hdr_decode u_dec (
        .word      (in_data),
        .last_rsel (last_rsel),
        .hdr       (hdr)
    );

    assign pay_take  = in_valid && (state == PS_PAY) && op_stores(cur_op);
    assign fdata_stb = pay_take && (cur_rsel == RSEL_FDRI);
    assign faddr_stb = pay_take && (cur_rsel == RSEL_FAR);

    cfgp_frame_track #(.FRAME_WORDS(FRAME_WORDS)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .fdata_stb  (fdata_stb),
        .faddr_stb  (faddr_stb),
        .word       (in_data),
        .frame_done (frm_done),
        .faddr_q    (faddr_q),
        .faddr_err  (far_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_HUNT;
            last_rsel <= '0;
            cur_rsel  <= '0;
            cur_op    <= OP_NOP;
            remain    <= '0;
            bad_hdr   <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_op     <= '0;
            frm_valid <= 1'b0;
            frm_data  <= '0;
        end else begin
            wr_valid  <= 1'b0;
            frm_valid <= 1'b0;
            if (in_valid) begin
                unique case (state)
                    PS_HUNT: begin
                        if (in_data == SYNC_WORD)
                            state <= PS_HDR;
                    end
                    PS_HDR: begin
                        if (in_data == SYNC_WORD) begin
                            state <= PS_HDR;
                        end else if (hdr.is_short || hdr.is_long) begin
                            if (hdr.is_short)
                                last_rsel <= hdr.rsel;
                            cur_rsel <= hdr.rsel;
                            cur_op   <= hdr.op;
                            remain   <= hdr.cnt;
                            if (hdr.op != OP_NOP && hdr.cnt != '0)
                                state <= PS_PAY;
                        end else begin
                            bad_hdr <= 1'b1;
                        end
                    end
                    PS_PAY: begin
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1))
                            state <= PS_HDR;
                        if (op_stores(cur_op)) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= cur_rsel;
                            wr_data  <= in_data;
                            wr_op    <= cur_op;
                            if (cur_rsel == RSEL_FDRI) begin
                                frm_valid <= 1'b1;
                                frm_data  <= in_data;
                            end
                        end
                        if (cur_op == OP_WR && cur_rsel == RSEL_CMD
                            && in_data[4:0] == CMD_DESYNC)
                            state <= PS_HUNT;
                    end
                    default: state <= PS_HUNT;
                endcase
            end
        end
    end

    assign in_ready   = 1'b1;
    assign synced     = (state != PS_HUNT);
    assign far_block  = faddr_q[23:21];
    assign far_bottom = faddr_q[20];
    assign far_row    = faddr_q[19:15];
    assign far_major  = faddr_q[14:7];
    assign far_minor  = faddr_q[6:0];
endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        synced,
    input logic        wr_valid,
    input logic [4:0]  wr_addr,
    input logic [1:0]  wr_op,
    input logic        frm_valid,
    input logic        frm_done,
    input logic        far_err,
    input logic        bad_hdr
);
    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> $past(in_valid && in_data == 32'hAA99_5566)); // R1
    AST_NO_STROBE_HUNTING: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(synced)); // R1
    AST_FRAME_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> (wr_valid && wr_addr == 5'b00010)); // R6
    AST_DONE_ON_WORD: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> frm_valid); // R7
    AST_FAR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        far_err |=> far_err); // R8
    AST_BAD_HDR_STICKY: assert property (@(posedge clk) disable iff (rst)
        bad_hdr |=> bad_hdr); // R5
    AST_NO_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> wr_op[1]); // R10
endmodule

bind cfg_stream_parser cfg_stream_parser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .synced    (synced),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_op     (wr_op),
    .frm_valid (frm_valid),
    .frm_done  (frm_done),
    .far_err   (far_err),
    .bad_hdr   (bad_hdr)
);

// File: tb/cfg_stream_parser_test.sv
module cfg_stream_parser_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, synced, wr_valid, frm_valid, frm_done;
    logic        far_bottom, far_err, bad_hdr;
    logic [4:0]  wr_addr, far_row;
    logic [31:0] wr_data, frm_data;
    logic [1:0]  wr_op;
    logic [2:0]  far_block;
    logic [7:0]  far_major;
    logic [6:0]  far_minor;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [31:0] SYNC = 32'hAA99_5566;

    always #5 clk = ~clk;

    cfg_stream_parser uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .synced(synced), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_op(wr_op),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_done(frm_done),
        .far_block(far_block), .far_bottom(far_bottom), .far_row(far_row),
        .far_major(far_major), .far_minor(far_minor),
        .far_err(far_err), .bad_hdr(bad_hdr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one word, return just after the edge that accepts it
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] short_hdr(input logic [1:0] op,
                                              input logic [4:0] rs,
                                              input logic [10:0] n);
        return {3'b001, op, 9'b0, rs, 2'b0, n};
    endfunction

    function automatic logic [31:0] long_hdr(input logic [1:0] op,
                                             input logic [26:0] n);
        return {3'b010, op, n};
    endfunction

    task automatic t_reset();
        chk(!synced && !wr_valid && !frm_valid && !frm_done, "R12 strobes/sync",
            {28'b0, synced, wr_valid, frm_valid, frm_done}, 32'h0);
        chk(!bad_hdr && !far_err, "R12 flags", {30'b0, bad_hdr, far_err}, 32'h0);
    endtask

    task automatic t_hunt();
        int strobes = 0;
        send(32'hFFFF_FFFF); strobes += wr_valid;
        send(32'h0000_0000); strobes += wr_valid;
        send(short_hdr(2'b10, 5'd1, 11'd1)); strobes += wr_valid;
        send(32'h0000_0010); strobes += wr_valid;
        chk(!synced && strobes == 0, "R1 ignored before sync",
            {31'b0, synced} + 32'(strobes), 32'h0);
        send(SYNC);
        chk(synced, "R1 synced after sync word", {31'b0, synced}, 32'h1);
    endtask

    task automatic t_nop_zero();
        send(32'h2000_0000);
        chk(!wr_valid, "R4 no-op header", {31'b0, wr_valid}, 32'h0);
        send(short_hdr(2'b10, 5'd2, 11'd0));
        chk(!wr_valid, "R4 zero count header", {31'b0, wr_valid}, 32'h0);
        send(short_hdr(2'b10, 5'd5, 11'd1));
        send(32'h1234_5678);
        chk(wr_valid && wr_addr == 5'd5 && wr_data == 32'h1234_5678 && wr_op == 2'b10,
            "R2 R4 write after empty headers", wr_data, 32'h1234_5678);
    endtask

    task automatic t_read_dec();
        int strobes = 0;
        send(short_hdr(2'b01, 5'd3, 11'd2));
        send(32'hAAAA_0001); strobes += wr_valid;
        send(32'hAAAA_0002); strobes += wr_valid;
        chk(strobes == 0, "R10 read payload silent", 32'(strobes), 32'h0);
        send(short_hdr(2'b11, 5'd12, 11'd1));
        send(32'h0424_A093);
        chk(wr_valid && wr_op == 2'b11 && wr_addr == 5'd12 && wr_data == 32'h0424_A093,
            "R11 decrypt write", {27'b0, wr_addr}, 32'd12);
        chk(!frm_valid, "R6 non-frame register", {31'b0, frm_valid}, 32'h0);
    endtask

    task automatic t_frames();
        int n_done = 0;
        int done_at = -1;
        int bad = 0;
        send(short_hdr(2'b10, 5'd2, 11'd0));
        send(long_hdr(2'b10, 27'd83));
        for (int i = 0; i < 83; i++) begin
            send(32'hF000_0000 + 32'(i));
            if (!(wr_valid && frm_valid && wr_addr == 5'd2 &&
                  frm_data == 32'hF000_0000 + 32'(i))) bad++;
            if (frm_done) begin n_done++; done_at = i; end
        end
        chk(bad == 0, "R3 R6 long packet frame words", 32'(bad), 32'h0);
        chk(n_done == 1 && done_at == 80, "R7 frame done on 81st word",
            32'(done_at), 32'd80);
        send(32'h2000_0000);
        chk(!wr_valid, "R3 long packet ended by count", {31'b0, wr_valid}, 32'h0);
    endtask

    task automatic t_far();
        logic [31:0] a = 32'h00A1_8305;
        send(short_hdr(2'b10, 5'd1, 11'd2));
        send(a);
        chk(far_block == a[23:21] && far_bottom == a[20] && far_row == a[19:15] &&
            far_major == a[14:7] && far_minor == a[6:0], "R8 fields decode",
            {far_block, far_bottom, far_row, far_major, far_minor}, a[23:0]);
        send(32'h00A1_8306);
        chk(!far_err, "R8 ascending ok", {31'b0, far_err}, 32'h0);
        send(short_hdr(2'b10, 5'd1, 11'd1));
        send(32'h00A1_8300);
        chk(far_err, "R8 descending flagged", {31'b0, far_err}, 32'h1);
        chk(far_minor == 7'd0, "R8 lower address loaded", {25'b0, far_minor}, 32'h0);
    endtask

    task automatic t_badhdr();
        send(32'h6000_0000);
        chk(bad_hdr && !wr_valid, "R5 bad header flagged", {31'b0, bad_hdr}, 32'h1);
        send(SYNC);
        send(short_hdr(2'b10, 5'd5, 11'd1));
        send(32'h0000_0077);
        chk(wr_valid && wr_data == 32'h77 && bad_hdr, "R5 recovers, flag sticky",
            wr_data, 32'h77);
    endtask

    task automatic t_desync();
        int strobes = 0;
        send(short_hdr(2'b10, 5'd4, 11'd1));
        send(32'h0000_000D);
        chk(wr_valid && wr_addr == 5'd4 && wr_data == 32'hD && !synced,
            "R9 desync strobe and sync drop", {31'b0, synced}, 32'h0);
        send(short_hdr(2'b10, 5'd5, 11'd1)); strobes += wr_valid;
        send(32'h0000_0099); strobes += wr_valid;
        chk(strobes == 0 && !synced, "R9 ignored after desync", 32'(strobes), 32'h0);
        send(SYNC);
        send(short_hdr(2'b10, 5'd5, 11'd1));
        send(32'h0000_0055);
        chk(synced && wr_valid && wr_data == 32'h55, "R9 R1 resync", wr_data, 32'h55);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_hunt();
        t_nop_zero();
        t_read_dec();
        t_frames();
        t_far();
        t_badhdr();
        t_desync();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule